// File: doc/BRIEF.md
# Multiply Low Word Execution Unit

This unit executes the signed 32x32 multiply-low operation of a fixed-point core. Each cycle it can accept an instruction word, the two source operand values already read from the register file, and the current sticky summary-overflow bit. It checks the opcode fields, multiplies the operands and returns the low 32 bits of the product for the target register, with the target register index.

Two flag bits in the instruction word choose the flag behaviour. One lets the overflow status be updated. The other lets a 4-bit condition field be written. Each of these outputs comes with its own write enable. All outputs are registered and appear one cycle after an accepted input, marked by an output valid pulse. An instruction word that fails the opcode check raises an illegal-decode flag and leaves every write enable low.

Top module: `mul_low_unit`

## Requirements
- R1: The instruction uses big-endian bit numbering, where numbered bit k is vector bit 31-k. Numbered bits 0-5 must equal 31 and bits 22-30 must equal 235. The target index is in bits 6-10 and the overflow-enable flag is bit 21. The record flag is bit 31.
- R2: The result is the low 32 bits of the signed 64-bit product of the two operands. The result and the target index are presented with a result write enable.
- R3: When overflow-enable is 1, OV is set to 1 if the signed product does not fit in 32 bits and cleared otherwise. The status write enable is asserted.
- R4: When overflow-enable is 1, the outgoing summary overflow is the incoming value ORed with the overflow. It is never cleared.
- R5: When overflow-enable is 0, the status write enable stays low. The outgoing summary overflow and OV equal the incoming summary overflow and 0.
- R6: When the record flag is 1, the condition field is written as {LT,GT,EQ,SO}, with weights 8,4,2,1. LT, GT and EQ compare the signed 32-bit result with 0. SO is the summary overflow after this instruction's own update. When the record flag is 0, the condition write enable stays low.
- R7: An opcode mismatch asserts the illegal flag and keeps all three write enables low.
- R8: The outputs are registered. The output valid is high exactly in the cycle after a valid input and low otherwise. An active-low synchronous reset clears every output to 0.
- R9: The carry bit is never modified. The carry write enable output is constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input valid |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| so_in | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Output valid pulse |
| illegal | output | 1 | Opcode check failed |
| rd_idx | output | 5 | Target register index |
| rd_data | output | 32 | Low product word |
| rd_we | output | 1 | Result write enable |
| so_out | output | 1 | Updated summary overflow |
| ov_out | output | 1 | Updated overflow |
| stat_we | output | 1 | Status write enable |
| ca_we | output | 1 | Carry write enable, always 0 |
| cr_field | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr_we | output | 1 | Condition write enable |

## Verification
The block has no parameters, so the bench builds it at its fixed 32-bit width. Random operands are drawn in several ranges so that both overflowing and non-overflowing products occur often. These are mixed with worked corner values: the most negative operand, zero, and products that land exactly on the signed 32-bit limits. All four flag combinations are run with summary overflow both set and clear, along with corrupted opcodes and reset applied in the middle of a stream.

// File: rtl/mul_low_unit.sv
module mul_low_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic        so_in,
  output logic        out_valid,
  output logic        illegal,
  output logic [4:0]  rd_idx,
  output logic [31:0] rd_data,
  output logic        rd_we,
  output logic        so_out,
  output logic        ov_out,
  output logic        stat_we,
  output logic        ca_we,
  output logic [3:0]  cr_field,
  output logic        cr_we
);

  logic        op_ok, oe, rc, ovf, so_nx, ov_nx;
  logic [63:0] prod;
  logic [31:0] lo;
  logic [3:0]  cr_nx;

  assign op_ok = (instr[31:26] == 6'd31) && (instr[9:1] == 9'd235);
  assign oe    = instr[10];
  assign rc    = instr[0];
  assign prod  = $signed(src_a) * $signed(src_b);
  assign lo    = prod[31:0];
  assign ovf   = prod[63:32] != {32{lo[31]}};
  assign ov_nx = oe & ovf;
  assign so_nx = so_in | (oe & ovf);
  assign cr_nx = {lo[31], ~lo[31] & (lo != 32'd0), lo == 32'd0, so_nx};
  assign ca_we = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; illegal <= 1'b0; rd_idx <= '0; rd_data <= '0;
      rd_we <= 1'b0; so_out <= 1'b0; ov_out <= 1'b0; stat_we <= 1'b0;
      cr_field <= '0; cr_we <= 1'b0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid & ~op_ok;
      rd_we     <= in_valid & op_ok;
      stat_we   <= in_valid & op_ok & oe;
      cr_we     <= in_valid & op_ok & rc;
      if (in_valid && op_ok) begin
        rd_idx   <= instr[25:21];
        rd_data  <= lo;
        so_out   <= so_nx;
        ov_out   <= ov_nx;
        cr_field <= cr_nx;
      end
    end
  end

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !rd_we && !stat_we && !cr_we);
  assert_sticky_so_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_ok && so_in) |=> so_out);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_ok && oe && ($signed(prod) == $signed({{32{lo[31]}}, lo}))) |=> !ov_out);
  assert_cr_so_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> cr_field[0] == so_out);
  assert_cr_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> $onehot(cr_field[3:1]));
  assert_we_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we || illegal) |-> out_valid);
  assert_no_carry_R9: assert property (@(posedge clk) !ca_we);

endmodule

// File: tb/tb_mul_low_unit.sv
module tb_mul_low_unit;
  logic clk = 0, rst_n = 0, in_valid = 0, so_in = 0;
  logic [31:0] instr = 0, src_a = 0, src_b = 0;
  logic out_valid, illegal, rd_we, so_out, ov_out, stat_we, ca_we, cr_we;
  logic [4:0] rd_idx;
  logic [31:0] rd_data;
  logic [3:0] cr_field;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  mul_low_unit dut (.*);

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [31:0] mk(input logic [4:0] rt, input logic oe, input logic rc);
    return {6'd31, rt, 5'd4, 5'd10, oe, 9'd235, rc};
  endfunction

  function automatic logic [31:0] e_lo(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] p;
    p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    return p[31:0];
  endfunction

  function automatic logic e_ovf(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] p;
    p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    return (p > 64'sh7FFFFFFF) || (p < -64'sh80000000);
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                     input logic si);
    logic good, oe, rc, ov, so;
    logic [31:0] lo;
    logic [3:0] cr;
    @(negedge clk);
    instr = ins; src_a = a; src_b = b; so_in = si; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    good = (ins[31:26] == 6'd31) && (ins[9:1] == 9'd235);
    oe = ins[10]; rc = ins[0];
    lo = e_lo(a, b);
    ov = oe & e_ovf(a, b);
    so = si | ov;
    cr = {lo[31], !lo[31] && lo != 0, lo == 0, so};
    chk("R8 valid", out_valid, 1);
    chk("R9 carry", ca_we, 0);
    if (!good) begin
      chk("R7 illegal", illegal, 1);
      chk("R7 enables", {rd_we, stat_we, cr_we}, 0);
    end else begin
      chk("R7 legal", illegal, 0);
      chk("R1 rd_idx", rd_idx, ins[25:21]);
      chk("R2 result", {rd_we, rd_data}, {1'b1, lo});
      if (oe) begin
        chk("R3 ov", {stat_we, ov_out}, {1'b1, ov});
        chk("R4 so", so_out, so);
      end else begin
        chk("R5 stat", {stat_we, so_out, ov_out}, {1'b0, si, 1'b0});
      end
      if (rc) chk("R6 cr", {cr_we, cr_field}, {1'b1, cr});
      else chk("R6 cr_we", cr_we, 0);
    end
    @(negedge clk);
    chk("R8 pulse", out_valid, 0);
  endtask

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R8 reset", {out_valid, rd_we, stat_we, cr_we, rd_data, so_out}, 0);
    rst_n = 1;
    run(mk(6, 0, 0), 32'h3000, 32'h7000, 0);
    chk("R2 ex1", rd_data, 32'h15000000);
    run(mk(6, 0, 1), 32'h4500, 32'h7000, 0);
    chk("R6 ex2", cr_field, 4'h4);
    run(mk(6, 1, 0), 32'h4500, 32'h70000, 0);
    chk("R3 ex3", {so_out, ov_out, 30'd0}, 32'hC0000000);
    run(mk(6, 1, 1), 32'h4500, 32'h7FFFFFFF, 0);
    chk("R6 ex4", {rd_data, cr_field}, {32'hFFFFBB00, 4'h9});
    run(mk(1, 1, 1), 32'h80000000, 32'hFFFFFFFF, 0);
    run(mk(2, 1, 1), 32'h80000000, 32'h1, 1);
    run(mk(3, 1, 1), 32'h10000, 32'h8000, 0);
    run(mk(3, 1, 1), 32'hFFFF0000, 32'h8000, 0);
    run(mk(3, 1, 1), 32'h10000, 32'h10000, 0);
    run(mk(4, 0, 1), 32'h0, 32'h12345, 1);
    run(mk(5, 1, 0), 32'h2, 32'h3, 1);
    run(mk(5, 0, 0), 32'h7FFFFFFF, 32'h7FFFFFFF, 1);
    run(mk(5, 1, 1) ^ 32'h8000_0000, 32'h5, 32'h5, 0);
    run(mk(5, 1, 1) ^ 32'h0000_0002, 32'h5, 32'h5, 1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b, ins;
      a = $urandom; b = $urandom;
      if (i % 3 == 1) begin a = a >> ($urandom % 32); b = b >> ($urandom % 32); end
      if (i % 3 == 2) begin a = $signed(a) >>> ($urandom % 32); b = $signed(b) >>> 16; end
      ins = mk($urandom, $urandom, $urandom);
      if ($urandom % 10 == 0) ins = ins ^ (32'h1 << ($urandom % 32));
      run(ins, a, b, $urandom);
    end
    @(negedge clk);
    instr = mk(7, 1, 1); src_a = 32'h40000000; src_b = 4; in_valid = 1;
    rst_n = 0;
    @(negedge clk);
    in_valid = 0;
    chk("R8 mid reset", {out_valid, rd_we, rd_data, so_out, ov_out}, 0);
    rst_n = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule